// File: doc/BRIEF.md
# Scan Test Port with Chained Device IDs

This block is a serial test access port of the usual four-wire kind. It is clocked by TCK. The TMS input steers the standard sixteen-state controller. The port holds a 46-bit instruction register and a 197-bit data chain. Each time the controller passes through Capture-DR, six 32-bit device identification codes are loaded into the chain. A tester sends bits in on TDI and reads them back on TDO. An active-low TRST returns the port to its reset state at any time, without waiting for a clock.

A two-bit revision input picks one of three sets of identification codes. Within a set, each code is built from a fixed 28-bit low part and a 4-bit revision nibble. The six low parts are, in order, 0x16C7057, 0x16C3057, 0x16C4057, 0x16C5057, 0x16C6057 and 0x16C6057. The codes sit in the chain at irregular offsets, and the gaps between them read as zero. The latched instruction is brought out as a plain vector for logic elsewhere to decode.

Top module: `scan_tap_core`

## Requirements
- R1: While trst_n is low, the controller is held in Test-Logic-Reset at once, without a clock edge. In that state tdo reads 0 and cur_instr reads 0.
- R2: The controller state changes only on a rising TCK edge and follows the standard sixteen-state graph. Five rising edges with TMS=1 reach Test-Logic-Reset from any state.
- R3: A rising edge in Capture-IR loads the instruction register with the value 1, so its two low bits are 01. The first two bits shifted out after that are 1 and then 0.
- R4: Each rising edge in Shift-IR moves the instruction register one place toward bit 0 and puts TDI into bit 45. TDO shows bit 0, so a TDI bit comes back out 46 shifts after it went in.
- R5: cur_instr changes only on the rising edge that leaves Update-IR. On that edge it takes the full 46-bit register. It keeps its value through Exit1-IR, Pause-IR, Exit2-IR and Update-IR.
- R6: A rising edge in Capture-DR fills the chain. Positions are numbered 0 to 196. Code k goes in with its MSB first, starting at position 1, 33, 65, 97, 130 or 162 for k = 0 to 5. Positions 0, 129 and 194 to 196 capture 0. During shifting, position 196 reaches TDO first and position 0 last.
- R7: rev_sel picks the revision nibble of each code. For codes 0 to 5 the nibbles are: 0 gives 1,2,1,2,1,1; 1 gives 3,3,2,3,2,2; 2 and 3 both give 4,4,3,4,3,3.
- R8: The chain is captured on every pass through Capture-DR, whatever instruction is latched.
- R9: Each rising edge in Shift-DR moves the chain by one bit and puts TDI in at position 0. After 197 shifts the TDI bits come out on TDO in the order they went in.
- R10: TDO is updated only on the falling TCK edge. It shows the low bit of the register being shifted while in Shift-DR or Shift-IR, and 0 in every other state.
- R11: The chain holds its contents through Exit1-DR, Pause-DR and Exit2-DR. When shifting resumes, the bit sequence carries on where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| rev_sel | input | 2 | Revision select for the ID code set |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| cur_instr | output | 46 | Latched instruction |

## Verification
The hardest behaviour to reach from the ports is the chain's own shift path: captured data always hides whatever the chain held before. To expose it, one Shift-DR session runs for 257 bits, so the last 60 bits come back as the TDI pattern fed in at the start. A second session leaves shifting partway through the third code, waits in Pause-DR and resumes, checking that no bit is lost or repeated. The asynchronous reset is applied between clock edges while in the middle of an instruction shift, and its effect is checked before the next edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int ID_W = 32;
    localparam int N_ID = 6;

    typedef enum logic [3:0] {
        ST_TLR    = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    // Chain position of the MSB of code k; one spare bit precedes code 4.
    function automatic int id_pos(input int k);
        return 1 + ID_W * k + ((k >= 4) ? 1 : 0);
    endfunction

    // Code k for a revision: revision nibble over a fixed 28-bit body.
    function automatic logic [ID_W-1:0] id_code(input logic [1:0] rev, input int k);
        logic [3:0]  nib;
        logic [27:0] body;
        case (k)
            0:       body = 28'h16C7057;
            1:       body = 28'h16C3057;
            2:       body = 28'h16C4057;
            3:       body = 28'h16C5057;
            default: body = 28'h16C6057;
        endcase
        case (rev)
            2'd0:    nib = (k == 1 || k == 3) ? 4'd2 : 4'd1;
            2'd1:    nib = (k == 2 || k >= 4) ? 4'd2 : 4'd3;
            default: nib = (k == 2 || k >= 4) ? 4'd3 : 4'd4;
        endcase
        return {nib, body};
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_TLR:    r_d.st = tms ? ST_TLR    : ST_IDLE;
            ST_IDLE:   r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r_d.st = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            default:   r_d.st = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q.st <= ST_TLR;
        else         r_q    <= r_d;
    end

    assign state_o = r_q.st;

    // R2: reset state is sticky while TMS stays high
    assert_tlr_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_TLR && tms) |=> (r_q.st == ST_TLR));

    // R2: both update states leave for Run-Test/Idle or Select-DR-Scan only
    assert_update_exit_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_UPD_DR || r_q.st == ST_UPD_IR)
        |=> (r_q.st == ST_IDLE || r_q.st == ST_SEL_DR));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter int IR_W = 46
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_i,
    input  logic            tdi,
    output logic            ir_lsb_o,
    output logic [IR_W-1:0] instr_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] instr;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            ST_CAP_IR: r_d.sh    = IR_W'(1);
            ST_SH_IR:  r_d.sh    = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.instr = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ir_lsb_o = r_q.sh[0];
    assign instr_o  = r_q.instr;

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (r_q.sh[1:0] == 2'b01));

    assert_shift_entry_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_SH_IR) |=> (r_q.sh[IR_W-1] == $past(tdi)
                                   && r_q.sh[IR_W-2:0] == $past(r_q.sh[IR_W-1:1])));

    assert_instr_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i != ST_UPD_IR) |=> $stable(r_q.instr));

endmodule

// File: rtl/scan_tap_idchain.sv
module scan_tap_idchain
    import scan_tap_pkg::*;
#(
    parameter int DR_W = 197
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state_i,
    input  logic       tdi,
    input  logic [1:0] rev_sel,
    output logic       dr_lsb_o
);

    // Register index i holds chain position DR_W-1-i, so index 0 leaves first.
    localparam int GAP_MID_IDX = DR_W - 1 - (id_pos(N_ID - 2) - 1);

    typedef struct packed {
        logic [DR_W-1:0] sh;
    } dr_regs_t;

    dr_regs_t        r_d, r_q;
    logic [DR_W-1:0] cap_v;

    always_comb begin
        cap_v = '0;
        for (int k = 0; k < N_ID; k++) begin
            cap_v[DR_W - 1 - id_pos(k) -: ID_W] = id_code(rev_sel, k);
        end
    end

    always_comb begin
        r_d = r_q;
        case (state_i)
            ST_CAP_DR: r_d.sh = cap_v;
            ST_SH_DR:  r_d.sh = {tdi, r_q.sh[DR_W-1:1]};
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign dr_lsb_o = r_q.sh[0];

    assert_capture_gaps_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR) |=> (r_q.sh[DR_W-1] == 1'b0 && r_q.sh[GAP_MID_IDX] == 1'b0
                                    && r_q.sh[0] == 1'b0));

    assert_first_code_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && rev_sel == 2'd0) |=> (r_q.sh[DR_W-2 -: ID_W] == 32'h116C7057));

    assert_shift_step_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_SH_DR) |=> (r_q.sh[DR_W-1] == $past(tdi)
                                   && r_q.sh[DR_W-2:0] == $past(r_q.sh[DR_W-1:1])));

    assert_pause_hold_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_EX1_DR || state_i == ST_PAU_DR || state_i == ST_EX2_DR)
        |=> $stable(r_q.sh));

endmodule

// File: rtl/scan_tap_core.sv
module scan_tap_core
    import scan_tap_pkg::*;
#(
    parameter int IR_W = 46,
    parameter int DR_W = 197
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic [1:0]      rev_sel,
    output logic            tdo,
    output logic [IR_W-1:0] cur_instr
);

    localparam int MIN_DR_W = id_pos(N_ID - 1) + ID_W;

    generate
        if (DR_W < MIN_DR_W) begin : g_dr_too_short
            $error("scan_tap_core: DR_W too small for the ID codes");
        end
    endgenerate

    tap_state_e state;
    logic       ir_lsb;
    logic       dr_lsb;

    typedef struct packed {
        logic tdo;
    } out_regs_t;

    out_regs_t o_d, o_q;

    scan_tap_fsm i_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    scan_tap_ir #(.IR_W(IR_W)) i_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_i  (state),
        .tdi      (tdi),
        .ir_lsb_o (ir_lsb),
        .instr_o  (cur_instr)
    );

    scan_tap_idchain #(.DR_W(DR_W)) i_chain (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_i  (state),
        .tdi      (tdi),
        .rev_sel  (rev_sel),
        .dr_lsb_o (dr_lsb)
    );

    always_comb begin
        o_d = o_q;
        case (state)
            ST_SH_DR: o_d.tdo = dr_lsb;
            ST_SH_IR: o_d.tdo = ir_lsb;
            default:  o_d.tdo = 1'b0;
        endcase
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo = o_q.tdo;

    assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_SH_DR || state == ST_SH_IR) |-> (tdo == 1'b0));

endmodule

// File: tb/test_scan_tap_core.sv
`timescale 1ns/1ps
module test_scan_tap_core;

    localparam int IR_W = 46;
    localparam int DR_W = 197;

    logic            tck = 1'b0;
    logic            trst_n;
    logic            tms;
    logic            tdi;
    logic [1:0]      rev_sel;
    logic            tdo;
    logic [IR_W-1:0] cur_instr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    logic chain_pos [0:DR_W-1];

    bit [31:0] idtab [3][6] = '{
        '{32'h116C7057, 32'h216C3057, 32'h116C4057, 32'h216C5057, 32'h116C6057, 32'h116C6057},
        '{32'h316C7057, 32'h316C3057, 32'h216C4057, 32'h316C5057, 32'h216C6057, 32'h216C6057},
        '{32'h416C7057, 32'h416C3057, 32'h316C4057, 32'h416C5057, 32'h316C6057, 32'h316C6057}
    };
    int starts [6] = '{1, 33, 65, 97, 130, 162};

    always #2.5 tck = ~tck;

    scan_tap_core #(.IR_W(IR_W), .DR_W(DR_W)) i_scan_tap_core (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .rev_sel   (rev_sel),
        .tdo       (tdo),
        .cur_instr (cur_instr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit tpat(input int k);
        return bit'(((k * 7) >> 2) & 1);
    endfunction

    task automatic fill_chain(input logic [1:0] sel);
        int set = (sel >= 2) ? 2 : int'(sel);
        for (int p = 0; p < DR_W; p++) chain_pos[p] = 1'b0;
        for (int k = 0; k < 6; k++)
            for (int b = 31; b >= 0; b--)
                chain_pos[starts[k] + 31 - b] = idtab[set][k][b];
    endtask

    // Driver: called at falling edge + 2 ns; pushes the TDO value expected
    // after the coming rising and falling edges.
    task automatic tick(input logic tms_v, input logic tdi_v, input bit chk,
                        input logic expv, input string tag);
        logic pre;
        tms = tms_v;
        tdi = tdi_v;
        if (chk) exp_q.push_back('{v: expv, tag: tag});
        pre = tdo;
        @(posedge tck);
        #1;
        if (chk) check(tdo === pre, "R10 hold at rising edge", tdo, pre);
        @(negedge tck);
        #2;
    endtask

    // Monitor: compares TDO against the queue after each falling edge.
    initial begin
        exp_t it;
        forever begin
            @(negedge tck);
            #1;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                check(tdo === it.v, it.tag, tdo, it.v);
            end
        end
    end

    task automatic dr_session(input logic [1:0] sel, input int n_obs, input int pause_at,
                              input string tag);
        rev_sel = sel;
        fill_chain(sel);
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        for (int k = 0; k < n_obs; k++) begin
            if (k == pause_at) begin
                tick(1'b1, 1'b0, 1, 1'b0, "R11 exit1 quiet");
                tick(1'b0, 1'b0, 1, 1'b0, "R11 pause quiet");
                tick(1'b0, 1'b0, 1, 1'b0, "R11 pause quiet");
                tick(1'b1, 1'b0, 1, 1'b0, "R11 exit2 quiet");
            end
            if (k < DR_W) tick(1'b0, tpat(k), 1, chain_pos[DR_W - 1 - k], tag);
            else          tick(1'b0, tpat(k), 1, tpat(k - (DR_W - 1)), "R9 tdi return");
        end
        tick(1'b1, 1'b0, 1, 1'b0, "R10 quiet in exit1");
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
    endtask

    task automatic ir_session(input logic [IR_W-1:0] kval, input logic [IR_W-1:0] old);
        localparam int S = 60;
        logic v [0:S-1];
        logic e;
        for (int m = 0; m < S; m++) v[m] = (m < S - IR_W) ? logic'(m & 1) : kval[m - (S - IR_W)];
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        for (int k = 0; k < S; k++) begin
            e = (k < IR_W) ? ((k == 0) ? 1'b1 : 1'b0) : v[k - IR_W];
            tick(1'b0, (k > 0) ? v[k - 1] : 1'b0, 1, e, (k < 2) ? "R3 capture" : "R4 ir shift");
        end
        tick(1'b1, v[S - 1], 1, 1'b0, "R10 quiet in exit1-ir");
        check(cur_instr === old, "R5 held in exit1", 64'(cur_instr), 64'(old));
        tick(1'b0, 1'b0, 1, 1'b0, "R10 quiet in pause-ir");
        check(cur_instr === old, "R5 held in pause", 64'(cur_instr), 64'(old));
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b1, 1'b0, 0, 1'b0, "");
        check(cur_instr === old, "R5 held in update", 64'(cur_instr), 64'(old));
        tick(1'b0, 1'b0, 0, 1'b0, "");
        check(cur_instr === kval, "R5 latched", 64'(cur_instr), 64'(kval));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [IR_W-1:0] k1 = 46'h2A5F0C3D91E7;
        trst_n  = 1'b0;
        tms     = 1'b1;
        tdi     = 1'b0;
        rev_sel = 2'd0;
        #12;
        check(tdo === 1'b0, "R1 reset tdo", tdo, 0);
        check(cur_instr === '0, "R1 reset instr", 64'(cur_instr), 0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        #1;

        tick(1'b0, 1'b0, 0, 1'b0, "");
        dr_session(2'd0, DR_W, -1, "R6 set0 chain");
        ir_session(k1, '0);
        dr_session(2'd1, DR_W, -1, "R8 R7 set1 chain");
        dr_session(2'd2, DR_W + 60, -1, "R7 set2 chain");
        dr_session(2'd3, DR_W, 90, "R11 R7 set3 chain");

        // R2: escape from the middle of Shift-DR with five TMS=1 edges
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1, 1'b0, "R2 escape quiet");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        dr_session(2'd0, 40, -1, "R2 capture after escape");

        // R1: asynchronous reset in the middle of Shift-IR
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b1, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 0, 1'b0, "");
        tick(1'b0, 1'b0, 1, 1'b1, "R3 capture before reset");
        check(cur_instr === k1, "R5 instr kept", 64'(cur_instr), 64'(k1));
        trst_n = 1'b0;
        #0.2;
        check(tdo === 1'b0, "R1 async tdo", tdo, 0);
        check(cur_instr === '0, "R1 async instr", 64'(cur_instr), 0);
        @(negedge tck);
        #1 trst_n = 1'b1;
        #1;
        tick(1'b0, 1'b0, 0, 1'b0, "");
        dr_session(2'd1, 40, -1, "R1 alive after reset");

        repeat (3) @(negedge tck);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule